// File: doc/BRIEF.md
# Halt-Mode Power Controller

This block puts a fully static microcontroller core into its low-power halt state and brings it back out. The core enters halt by writing a one to the halt request bit of its I/O port. From the edge that takes that write, the block drops the core clock enable and keeps it low. The program counter does not advance, and every register of the core keeps its contents.

There are two ways out of halt. The first is a reset: the active-low reset input reinitialises the controller and raises the PC-reload request, so the core restarts at address zero. The second is a rising edge on the wake pin. It ends halt without reinitialisation. The core clock is enabled again, the halt request bit is cleared and a one-cycle resume pulse is given, and the core continues from the instruction after the one that halted it.

The wake path is live only when the clock-option strap selects an external clock or an RC oscillator. In crystal mode that pin belongs to the oscillator, so its edges are ignored. The wake pin is sampled by a free-running sampling clock, so an edge is seen even while the core clock is gated.

Top module: `halt_pwr_ctrl`

## Requirements
- R1: While rst_ni is low, clk_en_o is 1, halt_bit_o is 0, resume_o is 0 and pc_load_o is 1.
- R2: After rst_ni rises, pc_load_o stays 1 through the second rising clock edge and is 0 from the third edge on.
- R3: A write (port_wr_i=1) with port_wdata_i=1 while running sets halt_bit_o to 1 and drops clk_en_o to 0 at the same clock edge.
- R4: A write with port_wdata_i=0 while running leaves halt_bit_o at 0 and clk_en_o at 1.
- R5: While halted, with strap code 1 (external clock) or 2 (RC), a rising edge on wake_i makes clk_en_o 1 and resume_o 1 at the third clock edge after the pin rises. resume_o lasts exactly one cycle.
- R6: The wake that ends halt clears halt_bit_o at the same edge that raises resume_o.
- R7: With strap code 0 (crystal) or 3 (unused), edges on wake_i never end halt: clk_en_o stays 0, halt_bit_o stays 1 and resume_o stays 0.
- R8: Pulling rst_ni low while halted ends halt at once: clk_en_o is 1, halt_bit_o is 0 and pc_load_o is 1, with no resume pulse.
- R9: Port writes made while halted, of either value, are ignored: halt_bit_o stays 1 and clk_en_o stays 0.
- R10: Wake edges that arrive while running have no effect: no resume pulse, clk_en_o stays 1 and halt_bit_o is unchanged.
- R11: Only a low-to-high transition wakes. A pin that is already high when halt begins, or a falling edge, does not end halt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running sampling clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| clk_opt_i | input | 2 | Clock-option strap: 0 crystal, 1 external, 2 RC, 3 unused |
| port_wr_i | input | 1 | Write strobe for the halt request bit |
| port_wdata_i | input | 1 | Value written to the halt request bit |
| wake_i | input | 1 | Asynchronous wake pin |
| clk_en_o | output | 1 | Core clock enable, low while halted |
| resume_o | output | 1 | One-cycle pulse when the pin wake ends halt |
| halt_bit_o | output | 1 | Current halt request bit, read back by the core |
| pc_load_o | output | 1 | Request to load the program counter with zero |

## Verification
A halt write takes effect at the first clock edge after it is presented. A wake-pin rise passes through two synchroniser stages and one edge flop, so its effect arrives at the third edge. Reset assertion acts at once. Reset release clears the PC-reload request at the third edge. The bench changes inputs only on falling edges and reads outputs on the following falling edge, one table row per cycle. The expected values in each row are placed at exactly these edge counts, and the reset checks count edges in the same way.

// File: rtl/hpc_pkg.sv
package hpc_pkg;

  typedef enum logic [1:0] {
    OPT_XTAL = 2'd0,
    OPT_EXT  = 2'd1,
    OPT_RC   = 2'd2,
    OPT_RSVD = 2'd3
  } clk_opt_e;

  typedef enum logic {
    ST_RUN  = 1'b0,
    ST_HALT = 1'b1
  } pwr_state_e;

endpackage

// File: rtl/hpc_rst_sync.sv
module hpc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic srst_no
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain_q;
  logic [LAST:0] chain_d;

  generate
    if (STAGES == 1) begin : g_single
      assign chain_d = 1'b1;
    end else begin : g_multi
      assign chain_d = {chain_q[LAST-1:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign srst_no = chain_q[LAST];

endmodule

// File: rtl/hpc_wake_edge.sv
module hpc_wake_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic srst_ni,
  input  logic wake_i,
  output logic rise_o
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] sync_q;
  logic [LAST:0] sync_d;
  logic          prev_q;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      assign sync_d = wake_i;
    end else begin : g_many
      assign sync_d = {sync_q[LAST-1:0], wake_i};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge srst_ni) begin
    if (!srst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= sync_q[LAST];
    end
  end

  assign rise_o = sync_q[LAST] & ~prev_q;

  // R11: a detected rise is a one-cycle event
  AST_RISE_SINGLE: assert property (@(posedge clk_i) disable iff (!srst_ni)
    rise_o |=> !rise_o) else $error("rise held"); // R11

endmodule

// File: rtl/hpc_halt_fsm.sv
module hpc_halt_fsm
  import hpc_pkg::*;
(
  input  logic     clk_i,
  input  logic     srst_ni,
  input  clk_opt_e clk_opt_i,
  input  logic     wr_i,
  input  logic     wdata_i,
  input  logic     wake_rise_i,
  output logic     clk_en_o,
  output logic     resume_o,
  output logic     halt_bit_o
);

  pwr_state_e state_q, state_d;
  logic       hbit_q, hbit_d;
  logic       resume_q, resume_d;
  logic       clk_en_q, clk_en_d;
  logic       pin_wake_ok;
  logic       wake_go;

  // the wake pin doubles as the crystal output, so only these straps let it wake
  assign pin_wake_ok = (clk_opt_i == OPT_EXT) || (clk_opt_i == OPT_RC);
  assign wake_go     = wake_rise_i & pin_wake_ok;

  always_comb begin
    state_d  = state_q;
    hbit_d   = hbit_q;
    resume_d = 1'b0;
    unique case (state_q)
      ST_RUN: begin
        if (wr_i) begin
          hbit_d = wdata_i;
          if (wdata_i) state_d = ST_HALT;
        end
      end
      ST_HALT: begin
        if (wake_go) begin
          state_d  = ST_RUN;
          hbit_d   = 1'b0;
          resume_d = 1'b1;
        end
      end
      default: state_d = ST_RUN;
    endcase
    clk_en_d = (state_d == ST_RUN);
  end

  always_ff @(posedge clk_i or negedge srst_ni) begin
    if (!srst_ni) begin
      state_q  <= ST_RUN;
      hbit_q   <= 1'b0;
      resume_q <= 1'b0;
      clk_en_q <= 1'b1;
    end else begin
      state_q  <= state_d;
      hbit_q   <= hbit_d;
      resume_q <= resume_d;
      clk_en_q <= clk_en_d;
    end
  end

  assign clk_en_o   = clk_en_q;
  assign resume_o   = resume_q;
  assign halt_bit_o = hbit_q;

  AST_FALL_NEEDS_WRITE: assert property (@(posedge clk_i) disable iff (!srst_ni)
    $fell(clk_en_q) |-> $past(wr_i && wdata_i)) else $error("gate w/o write"); // R3
  AST_RISE_NEEDS_RESUME: assert property (@(posedge clk_i) disable iff (!srst_ni)
    $rose(clk_en_q) |-> resume_q) else $error("ungate w/o resume"); // R5
  AST_RESUME_SINGLE: assert property (@(posedge clk_i) disable iff (!srst_ni)
    resume_q |=> !resume_q) else $error("resume too long"); // R5
  AST_RESUME_CLEARS_BIT: assert property (@(posedge clk_i) disable iff (!srst_ni)
    resume_q |-> !hbit_q) else $error("bit not cleared"); // R6
  AST_XTAL_NO_WAKE: assert property (@(posedge clk_i) disable iff (!srst_ni)
    resume_q |-> ($past(clk_opt_i) == OPT_EXT || $past(clk_opt_i) == OPT_RC))
    else $error("wake in crystal mode"); // R7
  AST_HALTED_BIT_HELD: assert property (@(posedge clk_i) disable iff (!srst_ni)
    ($past(!clk_en_q) && !clk_en_q) |-> $stable(hbit_q)) else $error("bit moved"); // R9

endmodule

// File: rtl/halt_pwr_ctrl.sv
module halt_pwr_ctrl
  import hpc_pkg::*;
#(
  parameter int RST_STAGES  = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] clk_opt_i,
  input  logic       port_wr_i,
  input  logic       port_wdata_i,
  input  logic       wake_i,
  output logic       clk_en_o,
  output logic       resume_o,
  output logic       halt_bit_o,
  output logic       pc_load_o
);

  logic     srst_n;
  logic     wake_rise;
  logic     pc_load_q;
  clk_opt_e opt;

  assign opt = clk_opt_e'(clk_opt_i);

  hpc_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .srst_no (srst_n)
  );

  hpc_wake_edge #(.SYNC_STAGES(SYNC_STAGES)) u_wake (
    .clk_i   (clk_i),
    .srst_ni (srst_n),
    .wake_i  (wake_i),
    .rise_o  (wake_rise)
  );

  hpc_halt_fsm u_fsm (
    .clk_i       (clk_i),
    .srst_ni     (srst_n),
    .clk_opt_i   (opt),
    .wr_i        (port_wr_i),
    .wdata_i     (port_wdata_i),
    .wake_rise_i (wake_rise),
    .clk_en_o    (clk_en_o),
    .resume_o    (resume_o),
    .halt_bit_o  (halt_bit_o)
  );

  // zero-vector load request: set by reset, dropped on the first edge after release
  always_ff @(posedge clk_i or negedge srst_n) begin
    if (!srst_n) pc_load_q <= 1'b1;
    else         pc_load_q <= 1'b0;
  end

  assign pc_load_o = pc_load_q;

  AST_PCLOAD_CLOCKED: assert property (@(posedge clk_i) disable iff (!srst_n)
    pc_load_q |-> clk_en_o) else $error("reload while gated"); // R2
  AST_PCLOAD_ONCE: assert property (@(posedge clk_i) disable iff (!srst_n)
    !pc_load_q |=> !pc_load_q) else $error("reload reappeared"); // R2
  AST_NO_RESUME_ON_RELOAD: assert property (@(posedge clk_i) disable iff (!srst_n)
    pc_load_q |-> !resume_o) else $error("resume with reload"); // R8

endmodule

// File: tb/tb_halt_pwr_ctrl.sv
module tb_halt_pwr_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 39;

  logic       clk;
  logic       rst_ni;
  logic [1:0] clk_opt;
  logic       port_wr;
  logic       port_wdata;
  logic       wake;
  logic       clk_en;
  logic       resume;
  logic       halt_bit;
  logic       pc_load;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  halt_pwr_ctrl dut (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .clk_opt_i    (clk_opt),
    .port_wr_i    (port_wr),
    .port_wdata_i (port_wdata),
    .wake_i       (wake),
    .clk_en_o     (clk_en),
    .resume_o     (resume),
    .halt_bit_o   (halt_bit),
    .pc_load_o    (pc_load)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // row: opt[11:10] wr[9] wd[8] wake[7] | exp clk_en[6] halt_bit[5] resume[4] | req[3:0]
  localparam logic [11:0] VEC [NVEC] = '{
    {2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd4},   // idle, R4
    {2'd1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd4},   // write 0, R4
    {2'd1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 4'd10},  // wake while running, R10
    {2'd1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 4'd10},  // R10
    {2'd1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 4'd10},  // R10
    {2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd10},  // R10
    {2'd1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 4'd3},   // halt write, R3
    {2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'd3},   // R3
    {2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'd9},   // write 0 while halted, R9
    {2'd1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 4'd5},   // pin rises, R5
    {2'd1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 4'd5},   // R5
    {2'd1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 4'd6},   // third edge, R5 R6
    {2'd1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 4'd5},   // pulse over, R5
    {2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd5},   // R5
    {2'd1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 4'd10},  // R10
    {2'd1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 4'd10},  // R10
    {2'd1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 4'd10},  // R10
    {2'd1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 4'd11},  // halt with pin high, R11
    {2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'd11},  // falling edge, R11
    {2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'd11},  // R11
    {2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'd11},  // R11
    {2'd1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 4'd11},  // new rise, R11
    {2'd1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 4'd11},  // R11
    {2'd1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 4'd11},  // wakes, R11
    {2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd5},   // R5
    {2'd2, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 4'd3},   // RC halt, R3
    {2'd2, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 4'd5},   // R5
    {2'd2, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 4'd5},   // R5
    {2'd2, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 4'd5},   // RC wake, R5
    {2'd2, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd5},   // R5
    {2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 4'd3},   // crystal halt, R3
    {2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 4'd7},   // R7
    {2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 4'd7},   // R7
    {2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 4'd7},   // R7
    {2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 4'd9},   // write 1 while halted, R9
    {2'd3, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 4'd7},   // unused strap, R7
    {2'd3, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 4'd7},   // R7
    {2'd3, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 4'd7},   // R7
    {2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'd7}    // R7
  };

  task automatic check(input string what, input int req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL R%0d %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    rst_ni = 1'b1; clk_opt = 2'd1; port_wr = 1'b0; port_wdata = 1'b0; wake = 1'b0;
    #2 rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("clk_en in reset", 1, clk_en, 1'b1);
    check("halt_bit in reset", 1, halt_bit, 1'b0);
    check("resume in reset", 1, resume, 1'b0);
    check("pc_load in reset", 1, pc_load, 1'b1);
    rst_ni = 1'b1;
    // R2: reload request drops at third edge after release
    @(posedge clk); @(negedge clk);
    check("pc_load edge1", 2, pc_load, 1'b1);
    @(posedge clk); @(negedge clk);
    check("pc_load edge2", 2, pc_load, 1'b1);
    @(posedge clk); @(negedge clk);
    check("pc_load edge3", 2, pc_load, 1'b0);

    for (int i = 0; i < NVEC; i++) begin
      clk_opt    = VEC[i][11:10];
      port_wr    = VEC[i][9];
      port_wdata = VEC[i][8];
      wake       = VEC[i][7];
      @(posedge clk); @(negedge clk);
      check($sformatf("row %0d clk_en", i), int'(VEC[i][3:0]), clk_en, VEC[i][6]);
      check($sformatf("row %0d halt_bit", i), int'(VEC[i][3:0]), halt_bit, VEC[i][5]);
      check($sformatf("row %0d resume", i), int'(VEC[i][3:0]), resume, VEC[i][4]);
    end
    port_wr = 1'b0; port_wdata = 1'b0;

    // R8: reset while halted (still halted in crystal-like strap)
    check("still halted before reset", 8, clk_en, 1'b0);
    #1 rst_ni = 1'b0;
    #1;
    check("clk_en after reset in halt", 8, clk_en, 1'b1);
    check("halt_bit after reset in halt", 8, halt_bit, 1'b0);
    check("pc_load after reset in halt", 8, pc_load, 1'b1);
    check("no resume on reset", 8, resume, 1'b0);
    @(negedge clk);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);
    check("pc_load cleared after reset", 2, pc_load, 1'b0);
    check("running after reset", 8, clk_en, 1'b1);

    // R7: crystal strap, full pin pulse while halted never wakes
    clk_opt = 2'd0; port_wr = 1'b1; port_wdata = 1'b1;
    @(negedge clk);
    port_wr = 1'b0; port_wdata = 1'b0;
    wake = 1'b1;
    repeat (5) @(negedge clk);
    wake = 1'b0;
    repeat (2) @(negedge clk);
    check("crystal clk_en", 7, clk_en, 1'b0);
    check("crystal halt_bit", 7, halt_bit, 1'b1);
    check("crystal resume", 7, resume, 1'b0);

    done = 1'b1;
    finish_run();
  end

endmodule